// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Read Sequencer

This block runs one read transaction at a time on an external bus where address and data share the same lanes. When the processor side raises a request while the sequencer is idle, the block captures the address, the byte-enable pattern and a 16-bit timing word. It then lowers the memory select, pulses the address-latch enable with the address on the lanes, and releases the lanes. Next it pulls the read strobe low for a programmable number of wait states, samples the returned data as the strobe rises, and finally releases the select and reports completion.

The sequencer is clocked by a tick at twice the bus clock rate. One tick is therefore half a bus clock, which lets every strobe edge fall on a half-clock boundary. All phase lengths below are given in ticks. The timing word is decoded as follows. Bits [14:12] set the latch-enable width. Bit 10 cleared adds a full clock of address hold. Bit 9 cleared adds a full clock of turnaround before the read strobe. Bits [3:0] set the read-strobe wait states.

The state machine has seven states: IDLE, SELECT, LATCH, ADDR_HOLD, TURN, STROBE and RECOVER. The transitions are:
- IDLE to SELECT on an accepted request.
- SELECT to LATCH after 1 tick.
- LATCH to ADDR_HOLD when the latch width has elapsed.
- ADDR_HOLD to TURN when the hold has elapsed and the turnaround is non-zero.
- ADDR_HOLD directly to STROBE when the turnaround is zero.
- TURN to STROBE when the turnaround has elapsed.
- STROBE to RECOVER when the wait states have elapsed, capturing the data.
- RECOVER to IDLE after 2 ticks, pulsing done.

Top module: `xrs_bus_reader`

## Requirements
- R1: While reset is high, and directly after it, the block is idle. That means select high, latch enable low, read strobe high, all byte enables high (inactive), lanes not driven, busy low and done low. A reset in mid-transaction returns the block to this state.
- R2: A request is taken only in a tick with busy low. Busy is high from the tick after acceptance until the done tick, where it is low. Requests raised while busy are ignored and start no second transaction.
- R3: The latch enable rises one tick after select goes low. It stays high for 2*(timing[14:12]+1) ticks.
- R4: The lanes carry the captured address with output enable high from select-low until the address hold ends. The hold is 1 tick after latch enable falls, plus 2 ticks when timing bit 10 is 0.
- R5: The read strobe falls 1 + 2*(number of timing bits 10 and 9 that are 0) ticks after the latch enable falls.
- R6: The read strobe stays low for 2*(timing[3:0]+1) ticks.
- R7: The byte enables are active low. They show the bitwise inverse of the requested pattern only during the last 2 ticks of read strobe low, and are all high otherwise.
- R8: Select rises 2 ticks after the read strobe rises. The lanes stay undriven from the end of the address hold until select rises.
- R9: The read data output takes the lane value present in the last strobe-low tick. Done is high for exactly one tick, the first tick with select high again.
- R10: The timing word is captured at acceptance. Changing it during a transaction does not change that transaction's phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate tick clock (one tick is half a bus clock) |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Read request |
| req_addr_i | input | LANE_W | Address to place on the lanes |
| req_be_i | input | LANE_W/8 | Requested byte lanes, 1 = wanted |
| cfg_i | input | PAR_W | Timing word |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-tick completion pulse |
| rdata_o | output | LANE_W | Data captured at the read strobe rise |
| bus_sel_n_o | output | 1 | Memory select, active low |
| bus_ale_o | output | 1 | Address-latch enable, active high |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_be_n_o | output | LANE_W/8 | Byte enables, active low |
| bus_ad_o | output | LANE_W | Address driven onto the shared lanes |
| bus_ad_oe_o | output | 1 | Lane output enable |
| bus_ad_i | input | LANE_W | Lane value returned by memory |

## Verification
The completion pulse of one transaction and the acceptance of the next request can fall in the same tick. The done tick is an idle tick, so a request present then is taken at once. The table-driven loop provokes this by issuing every vector back to back, raising the next request in the very tick where done is seen. Each new transaction is then judged by select falling in the following tick with done already low. Its full phase timing and captured data must still match the values expected from its own timing word.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_LATCH,
        ST_ADDR_HOLD,
        ST_TURN,
        ST_STROBE,
        ST_RECOVER
    } xrs_state_e;

    localparam int LATCH_FIELD_LO = 12;
    localparam int LATCH_FIELD_W  = 3;
    localparam int HOLD_BIT       = 10;
    localparam int TURN_BIT       = 9;
    localparam int WAIT_FIELD_LO  = 0;
    localparam int WAIT_FIELD_W   = 4;

endpackage

// File: rtl/xrs_phase_calc.sv
module xrs_phase_calc
    import xrs_pkg::*;
#(
    parameter int PAR_W = 16,
    parameter int CNT_W = 6
) (
    input  logic [PAR_W-1:0] cfg_i,
    output logic [CNT_W-1:0] latch_len_o,
    output logic [CNT_W-1:0] hold_len_o,
    output logic [CNT_W-1:0] turn_len_o,
    output logic [CNT_W-1:0] strobe_len_o
);

    logic [LATCH_FIELD_W-1:0] latch_field;
    logic [WAIT_FIELD_W-1:0]  wait_field;

    assign latch_field = cfg_i[LATCH_FIELD_LO +: LATCH_FIELD_W];
    assign wait_field  = cfg_i[WAIT_FIELD_LO +: WAIT_FIELD_W];

    always_comb begin
        latch_len_o  = CNT_W'({latch_field, 1'b0}) + CNT_W'(2);
        strobe_len_o = CNT_W'({wait_field, 1'b0}) + CNT_W'(2);
        hold_len_o   = cfg_i[HOLD_BIT] ? CNT_W'(1) : CNT_W'(3);
        turn_len_o   = cfg_i[TURN_BIT] ? CNT_W'(0) : CNT_W'(2);
    end

endmodule

// File: rtl/xrs_tick_counter.sv
module xrs_tick_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign count_o = cnt_q;
    assign last_o  = (cnt_q == '0);

endmodule

// File: rtl/xrs_fsm.sv
module xrs_fsm
    import xrs_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             last_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] latch_len_i,
    input  logic [CNT_W-1:0] hold_len_i,
    input  logic [CNT_W-1:0] turn_len_i,
    input  logic [CNT_W-1:0] strobe_len_i,
    output xrs_state_e       state_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             strobe_end_o,
    output logic             cycle_end_o,
    output logic             sel_n_o,
    output logic             ale_o,
    output logic             rd_n_o,
    output logic             oe_o,
    output logic             be_win_o
);

    xrs_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        load_o       = 1'b0;
        load_val_o   = '0;
        strobe_end_o = 1'b0;
        cycle_end_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d    = ST_SELECT;
                    load_o     = 1'b1;
                    load_val_o = '0;
                end
            end
            ST_SELECT: begin
                if (last_i) begin
                    state_d    = ST_LATCH;
                    load_o     = 1'b1;
                    load_val_o = latch_len_i - CNT_W'(1);
                end
            end
            ST_LATCH: begin
                if (last_i) begin
                    state_d    = ST_ADDR_HOLD;
                    load_o     = 1'b1;
                    load_val_o = hold_len_i - CNT_W'(1);
                end
            end
            ST_ADDR_HOLD: begin
                if (last_i) begin
                    load_o = 1'b1;
                    if (turn_len_i != '0) begin
                        state_d    = ST_TURN;
                        load_val_o = turn_len_i - CNT_W'(1);
                    end else begin
                        state_d    = ST_STROBE;
                        load_val_o = strobe_len_i - CNT_W'(1);
                    end
                end
            end
            ST_TURN: begin
                if (last_i) begin
                    state_d    = ST_STROBE;
                    load_o     = 1'b1;
                    load_val_o = strobe_len_i - CNT_W'(1);
                end
            end
            ST_STROBE: begin
                if (last_i) begin
                    state_d      = ST_RECOVER;
                    load_o       = 1'b1;
                    load_val_o   = CNT_W'(1);
                    strobe_end_o = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (last_i) begin
                    state_d     = ST_IDLE;
                    cycle_end_o = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sel_n_o  = 1'b1;
        ale_o    = 1'b0;
        rd_n_o   = 1'b1;
        oe_o     = 1'b0;
        be_win_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SELECT: begin
                sel_n_o = 1'b0;
                oe_o    = 1'b1;
            end
            ST_LATCH: begin
                sel_n_o = 1'b0;
                ale_o   = 1'b1;
                oe_o    = 1'b1;
            end
            ST_ADDR_HOLD: begin
                sel_n_o = 1'b0;
                oe_o    = 1'b1;
            end
            ST_TURN: sel_n_o = 1'b0;
            ST_STROBE: begin
                sel_n_o  = 1'b0;
                rd_n_o   = 1'b0;
                be_win_o = (count_i < CNT_W'(2));
            end
            ST_RECOVER: sel_n_o = 1'b0;
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R3: the select phase lasts exactly one tick before the latch phase
    assert_select_one_tick_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_SELECT) |=> (state_q == ST_LATCH));

    // R8: the recover phase always ends in idle or continues recovering
    assert_recover_exit_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RECOVER) |=> (state_q == ST_RECOVER || state_q == ST_IDLE));

endmodule

// File: rtl/xrs_bus_reader.sv
module xrs_bus_reader
    import xrs_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int PAR_W  = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  req_i,
    input  logic [LANE_W-1:0]     req_addr_i,
    input  logic [LANE_W/8-1:0]   req_be_i,
    input  logic [PAR_W-1:0]      cfg_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [LANE_W-1:0]     rdata_o,
    output logic                  bus_sel_n_o,
    output logic                  bus_ale_o,
    output logic                  bus_rd_n_o,
    output logic [LANE_W/8-1:0]   bus_be_n_o,
    output logic [LANE_W-1:0]     bus_ad_o,
    output logic                  bus_ad_oe_o,
    input  logic [LANE_W-1:0]     bus_ad_i
);

    localparam int BE_W    = LANE_W / 8;
    localparam int MAX_LEN = 2 * (1 << WAIT_FIELD_W);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    xrs_state_e        state;
    logic              start;
    logic              load, last, strobe_end, cycle_end, be_win, oe;
    logic [CNT_W-1:0]  load_val, count;
    logic [CNT_W-1:0]  latch_len, hold_len, turn_len, strobe_len;

    logic [PAR_W-1:0]  cfg_q;
    logic [LANE_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;
    logic [LANE_W-1:0] rdata_q;
    logic              done_q;

    assign start = req_i && (state == ST_IDLE);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q   <= '0;
            addr_q  <= '0;
            be_q    <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (start) begin
                cfg_q  <= cfg_i;
                addr_q <= req_addr_i;
                be_q   <= req_be_i;
            end
            if (strobe_end) rdata_q <= bus_ad_i;
            done_q <= cycle_end;
        end
    end

    xrs_phase_calc #(.PAR_W(PAR_W), .CNT_W(CNT_W)) calc_i (
        .cfg_i        (cfg_q),
        .latch_len_o  (latch_len),
        .hold_len_o   (hold_len),
        .turn_len_o   (turn_len),
        .strobe_len_o (strobe_len)
    );

    xrs_tick_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load),
        .load_val_i (load_val),
        .count_o    (count),
        .last_o     (last)
    );

    xrs_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .start_i      (start),
        .last_i       (last),
        .count_i      (count),
        .latch_len_i  (latch_len),
        .hold_len_i   (hold_len),
        .turn_len_i   (turn_len),
        .strobe_len_i (strobe_len),
        .state_o      (state),
        .load_o       (load),
        .load_val_o   (load_val),
        .strobe_end_o (strobe_end),
        .cycle_end_o  (cycle_end),
        .sel_n_o      (bus_sel_n_o),
        .ale_o        (bus_ale_o),
        .rd_n_o       (bus_rd_n_o),
        .oe_o         (oe),
        .be_win_o     (be_win)
    );

    assign bus_ad_oe_o = oe;
    assign bus_ad_o    = oe ? addr_q : '0;
    assign bus_be_n_o  = be_win ? ~be_q : '1;
    assign busy_o      = (state != ST_IDLE);
    assign done_o      = done_q;
    assign rdata_o     = rdata_q;

    assert_ale_after_sel_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(bus_sel_n_o) |=> bus_ale_o);

    assert_be_inside_strobe_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_be_n_o != '1) |-> !bus_rd_n_o);

    assert_no_drive_in_read_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_rd_n_o |-> !bus_ad_oe_o);

    assert_sel_over_rd_rise_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(bus_rd_n_o) |-> !bus_sel_n_o);

    assert_done_single_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    assert_done_when_released_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (bus_sel_n_o && !busy_o));

    assert_cfg_frozen_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && $past(busy_o)) |-> $stable(cfg_q));

endmodule

// File: tb/xrs_bus_reader_tb.sv
module xrs_bus_reader_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    typedef struct packed {
        logic [15:0] cfg;
        logic [15:0] addr;
        logic [15:0] data;
        logic [1:0]  be;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 16'h1234, 16'hA55A, 2'b11},
        '{16'h0600, 16'h00F0, 16'h0F0F, 2'b01},
        '{16'h7F0F, 16'hBEEF, 16'h1357, 2'b10},
        '{16'h0400, 16'h4321, 16'hFFFF, 2'b11},
        '{16'h0200, 16'h8001, 16'h0001, 2'b01},
        '{16'h3203, 16'h5A5A, 16'hC3C3, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] cfg = '0;
    logic        busy, done, sel_n, ale, rd_n, ad_oe;
    logic [15:0] rdata, ad_o, ad_i;
    logic [1:0]  be_n;
    logic [15:0] mem_data = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ad_i = rd_n ? 16'hDEAD : mem_data;

    xrs_bus_reader dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .req_i       (req),
        .req_addr_i  (req_addr),
        .req_be_i    (req_be),
        .cfg_i       (cfg),
        .busy_o      (busy),
        .done_o      (done),
        .rdata_o     (rdata),
        .bus_sel_n_o (sel_n),
        .bus_ale_o   (ale),
        .bus_rd_n_o  (rd_n),
        .bus_be_n_o  (be_n),
        .bus_ad_o    (ad_o),
        .bus_ad_oe_o (ad_oe),
        .bus_ad_i    (ad_i)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check(sel_n == 1'b1 && ale == 1'b0 && rd_n == 1'b1 && be_n == 2'b11 &&
              ad_oe == 1'b0 && busy == 1'b0 && done == 1'b0, tag,
              {sel_n, ale, rd_n, be_n, ad_oe, busy, done}, 8'b1_0_1_11_0_0_0);
    endtask

    // Starts at a falling edge; returns at the falling edge of the done tick.
    task automatic run_read(input vec_t v, input bit hold_req, input bit mid_cfg);
        int a_len, h_len, g_len, w_len;
        int ale_first, ale_cnt, ale_fall, oe_off, rd_fall, rd_cnt, rd_rise;
        int be_first, be_cnt, sel_rise, done_t;
        bit addr_bad, oe_reon, be_bad, busy_bad;
        a_len = 2 * (int'(v.cfg[14:12]) + 1);
        h_len = v.cfg[10] ? 1 : 3;
        g_len = v.cfg[9] ? 0 : 2;
        w_len = 2 * (int'(v.cfg[3:0]) + 1);
        ale_first = -1; ale_cnt = 0; ale_fall = -1; oe_off = -1; rd_fall = -1;
        rd_cnt = 0; rd_rise = -1; be_first = -1; be_cnt = 0; sel_rise = -1; done_t = -1;
        addr_bad = 0; oe_reon = 0; be_bad = 0; busy_bad = 0;

        cfg = v.cfg; req_addr = v.addr; req_be = v.be; mem_data = v.data; req = 1'b1;
        @(negedge clk);
        for (int t = 0; t < 200; t++) begin
            if (t == 0) begin
                check(sel_n == 1'b0 && done == 1'b0, "R2 accepted, select low, done low",
                      {sel_n, done}, 0);
                if (mid_cfg) cfg = ~v.cfg;
                if (hold_req) req_addr = ~v.addr;
                else req = 1'b0;
            end
            if (hold_req && t == 3) req = 1'b0;
            if (ale) begin
                ale_cnt++;
                if (ale_first < 0) ale_first = t;
                if (ad_o != v.addr || !ad_oe) addr_bad = 1;
            end
            if (!ale && ale_first >= 0 && ale_fall < 0) ale_fall = t;
            if (!ad_oe && oe_off < 0) oe_off = t;
            if (ad_oe && oe_off >= 0 && !done) oe_reon = 1;
            if (!rd_n) begin
                rd_cnt++;
                if (rd_fall < 0) rd_fall = t;
            end
            if (rd_n && rd_fall >= 0 && rd_rise < 0) rd_rise = t;
            if (be_n != 2'b11) begin
                be_cnt++;
                if (be_first < 0) be_first = t;
                if (be_n != ~v.be) be_bad = 1;
            end
            if (sel_n && sel_rise < 0) sel_rise = t;
            if (!done && !busy && t > 0) busy_bad = 1;
            if (done) begin
                done_t = t;
                break;
            end
            @(negedge clk);
        end

        check(ale_first == 1, "R3 latch enable one tick after select", ale_first, 1);
        check(ale_cnt == a_len, "R3 latch enable width", ale_cnt, a_len);
        check(addr_bad == 0, "R4 address on lanes during latch", addr_bad, 0);
        check(oe_off == a_len + 1 + h_len, "R4 address hold end", oe_off, a_len + 1 + h_len);
        check(rd_fall == ale_fall + 1 + h_len - 1 + g_len, "R5 read strobe fall after latch fall",
              rd_fall - ale_fall, h_len + g_len);
        check(rd_cnt == w_len && rd_rise == rd_fall + w_len, "R6 read strobe low width",
              rd_cnt, w_len);
        check(be_cnt == 2 && be_first == rd_rise - 2 && !be_bad, "R7 byte enable window",
              be_first, rd_rise - 2);
        check(sel_rise == rd_rise + 2, "R8 select release after strobe rise", sel_rise, rd_rise + 2);
        check(oe_reon == 0, "R8 lanes undriven until release", oe_reon, 0);
        check(done_t == sel_rise && busy == 1'b0, "R9 done on release tick, busy low (R2)",
              done_t, sel_rise);
        check(busy_bad == 0, "R2 busy held during transaction", busy_bad, 0);
        check(rdata == v.data, "R9 captured read data", rdata, v.data);
        if (mid_cfg)
            check(rd_rise == a_len + 1 + h_len + g_len + w_len,
                  "R10 timing word frozen at acceptance", rd_rise, a_len + 1 + h_len + g_len + w_len);
        cfg = v.cfg;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 outputs idle during reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 outputs idle after reset");

        // Table walk: vectors issued back to back, next request raised in done tick.
        for (int i = 0; i < NVEC; i++) run_read(VECS[i], 1'b0, 1'b0);

        // R2: request held through busy must not start a second transaction.
        @(negedge clk);
        run_read(VECS[4], 1'b1, 1'b0);
        req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(sel_n == 1'b1 && done == 1'b0 && busy == 1'b0, "R2 busy request ignored",
                  {sel_n, done, busy}, 3'b100);
        end

        // R10: timing word changed right after acceptance.
        run_read(VECS[0], 1'b0, 1'b1);
        @(negedge clk);
        run_read(VECS[1], 1'b0, 1'b1);

        // R1: reset in the middle of a transaction.
        @(negedge clk);
        cfg = 16'h7F0F; req_addr = 16'h7777; req_be = 2'b11; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1 mid-transaction reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 idle after mid-transaction reset");

        // Block still works after that reset.
        run_read(VECS[5], 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule